// File: doc/BRIEF.md
# QoS Bus Arbiter with Least-Recently-Granted Tiebreak

This block decides, once per clock, which of several masters gets the single shared target. Every master has two programmable 4-bit service levels: one for reads and one for writes. The request's read/write flag selects which of the two levels that request competes with. The highest level wins. Among equal levels, the master that has waited longest since its last grant wins. An age ranking of all masters records this order.

Each master is also placed in one of three priority groups: high, medium or low. A combinational checker raises `config_error` when the programmed levels would let the groups' bands overlap. Arbitration ignores the groups and the error flag, and it keeps running on the raw levels. The grant is a registered one-hot vector with a valid flag. A small write port loads the levels and the group codes, one field per write.

Top module: `qos_lrg_arbiter`

## Requirements
- R1: While reset is asserted, `grant` is all zeros and `grant_valid` and `config_error` are low. After reset, every level is 0, every master is in the high group, and the age ranking follows master index with master 0 the least recently granted.
- R2: The requests present before a clock edge are arbitrated at that edge. `grant` then holds exactly one set bit, which belongs to a master that was requesting, and `grant_valid` is high.
- R3: Among the requesting masters, the grant goes to the master whose effective service level is numerically largest.
- R4: A master's effective level is its write level when its `req_write` bit is 1, and its read level when that bit is 0.
- R5: Among requesting masters that share the largest level, the least recently granted master wins. The granted master becomes the most recent, and all other masters keep their relative order.
- R6: At an edge with no requests, `grant` becomes zero and `grant_valid` goes low. The age ranking stays unchanged.
- R7: A write with `cfg_we` high stores `cfg_data` into master `cfg_master`. The field is chosen by `cfg_sel`: 0 for the read level, 1 for the write level, 2 for the group. Group codes in `cfg_data[1:0]` are 0 = high, 1 = medium, 2 = low, and 3 is stored as low. The new value first applies to the arbitration at the following edge.
- R8: `config_error` is high exactly when two groups have members and some member of the lower group has a read or write level greater than or equal to a read or write level of some member of the higher group. The pairs checked are low/medium, low/high and medium/high. An empty group imposes no constraint.
- R9: While `config_error` is high, arbitration still follows R3 to R5 on the raw levels. Group membership never changes a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N_MST | Request, one bit per master |
| req_write | input | N_MST | 1 = the request is a write, 0 = a read |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_master | input | clog2(N_MST) | Master the write targets |
| cfg_sel | input | 2 | Field: 0 read level, 1 write level, 2 group |
| cfg_data | input | QOS_W | Value to store |
| grant | output | N_MST | Registered one-hot grant |
| grant_valid | output | 1 | A grant was issued at the last edge |
| config_error | output | 1 | Group bands overlap |

## Verification
The hardest state to reach from the ports is an age ranking that is no longer index order and that then decides a tie. That ranking must survive idle cycles and grants won by a higher level without being disturbed. The stimulus first builds a known ranking with all-equal contention. It then inserts idle cycles and single-winner grants driven by higher levels. Finally it re-creates the tie, so the bench's ordered-list model fixes one winner. A long pseudo-random phase mixes level rewrites into the traffic. This pushes the ranking through many permutations that the directed steps do not reach.

// File: rtl/qarb_pkg.sv
`timescale 1ns/1ps
package qarb_pkg;
  typedef enum logic [1:0] {
    GRP_HIGH = 2'd0,
    GRP_MID  = 2'd1,
    GRP_LOW  = 2'd2
  } grp_e;

  localparam logic [1:0] SEL_RD  = 2'd0;
  localparam logic [1:0] SEL_WR  = 2'd1;
  localparam logic [1:0] SEL_GRP = 2'd2;

  // Normalise a raw group code; the unused code folds onto the low group.
  function automatic logic [1:0] to_grp(input logic [1:0] raw);
    return (raw == 2'd3) ? GRP_LOW : raw;
  endfunction
endpackage

// File: rtl/qarb_cfg_regs.sv
`timescale 1ns/1ps
module qarb_cfg_regs #(
  parameter int N_MST = 4,
  parameter int QOS_W = 4,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [IDX_W-1:0]             cfg_master,
  input  logic [1:0]                   cfg_sel,
  input  logic [QOS_W-1:0]             cfg_data,
  output logic [N_MST-1:0][QOS_W-1:0]  rd_qos,
  output logic [N_MST-1:0][QOS_W-1:0]  wr_qos,
  output logic [N_MST-1:0][1:0]        grp
);
  import qarb_pkg::*;

  for (genvar i = 0; i < N_MST; i++) begin : g_slot
    logic hit;
    assign hit = cfg_we && (cfg_master == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_qos[i] <= '0;
        wr_qos[i] <= '0;
        grp[i]    <= GRP_HIGH;
      end else if (hit) begin
        case (cfg_sel)
          SEL_RD:  rd_qos[i] <= cfg_data;
          SEL_WR:  wr_qos[i] <= cfg_data;
          SEL_GRP: grp[i]    <= to_grp(cfg_data[1:0]);
          default: ;
        endcase
      end
    end
  end

  // R7
  grp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_GRP) |=> (grp[$past(cfg_master)] != 2'd3));
endmodule

// File: rtl/qarb_band_check.sv
`timescale 1ns/1ps
module qarb_band_check #(
  parameter int N_MST = 4,
  parameter int QOS_W = 4
) (
  input  logic [N_MST-1:0][QOS_W-1:0] rd_qos,
  input  logic [N_MST-1:0][QOS_W-1:0] wr_qos,
  input  logic [N_MST-1:0][1:0]       grp,
  output logic                        cfg_err
);
  localparam int N_GRP = 3;

  logic [N_GRP-1:0]            present;
  logic [N_GRP-1:0][QOS_W-1:0] lvl_min;
  logic [N_GRP-1:0][QOS_W-1:0] lvl_max;

  // Lower band must sit strictly under the higher band when both are populated.
  function automatic logic clash(input logic lo_p, input logic hi_p,
                                 input logic [QOS_W-1:0] lo_max,
                                 input logic [QOS_W-1:0] hi_min);
    return lo_p && hi_p && (lo_max >= hi_min);
  endfunction

  always_comb begin
    present = '0;
    lvl_min = '1;
    lvl_max = '0;
    for (int g = 0; g < N_GRP; g++) begin
      for (int i = 0; i < N_MST; i++) begin
        if (grp[i] == 2'(g)) begin
          present[g] = 1'b1;
          if (rd_qos[i] < lvl_min[g]) lvl_min[g] = rd_qos[i];
          if (wr_qos[i] < lvl_min[g]) lvl_min[g] = wr_qos[i];
          if (rd_qos[i] > lvl_max[g]) lvl_max[g] = rd_qos[i];
          if (wr_qos[i] > lvl_max[g]) lvl_max[g] = wr_qos[i];
        end
      end
    end
  end

  // group codes: 0 high, 1 medium, 2 low
  assign cfg_err = clash(present[2], present[1], lvl_max[2], lvl_min[1])
                 | clash(present[2], present[0], lvl_max[2], lvl_min[0])
                 | clash(present[1], present[0], lvl_max[1], lvl_min[0]);
endmodule

// File: rtl/qarb_age_rank.sv
`timescale 1ns/1ps
module qarb_age_rank #(
  parameter int N_MST = 4,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         upd,
  input  logic [IDX_W-1:0]             win_idx,
  output logic [N_MST-1:0][IDX_W-1:0]  rank
);
  localparam logic [IDX_W-1:0] NEWEST = IDX_W'(N_MST - 1);

  // rank 0 = least recently granted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_MST; i++) rank[i] <= IDX_W'(i);
    end else if (upd) begin
      for (int i = 0; i < N_MST; i++) begin
        if (win_idx == IDX_W'(i))         rank[i] <= NEWEST;
        else if (rank[i] > rank[win_idx]) rank[i] <= rank[i] - 1'b1;
      end
    end
  end

  logic [N_MST-1:0] seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < N_MST; i++) seen[rank[i]] = 1'b1;
  end

  // R5
  rank_perm_chk: assert property (@(posedge clk) disable iff (!rst_n) seen == '1);
endmodule

// File: rtl/qarb_select.sv
`timescale 1ns/1ps
module qarb_select #(
  parameter int N_MST = 4,
  parameter int QOS_W = 4,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic [N_MST-1:0]             req,
  input  logic [N_MST-1:0]             req_write,
  input  logic [N_MST-1:0][QOS_W-1:0]  rd_qos,
  input  logic [N_MST-1:0][QOS_W-1:0]  wr_qos,
  input  logic [N_MST-1:0][IDX_W-1:0]  rank,
  output logic [N_MST-1:0][QOS_W-1:0]  cand_qos,
  output logic                         any_req,
  output logic [IDX_W-1:0]             win_idx,
  output logic [QOS_W-1:0]             win_qos
);
  localparam int KEY_W = QOS_W + IDX_W;

  // Level first; inverted age breaks ties towards the oldest grant.
  function automatic logic [KEY_W-1:0] sort_key(input logic [QOS_W-1:0] q,
                                                input logic [IDX_W-1:0] r);
    return {q, ~r};
  endfunction

  for (genvar i = 0; i < N_MST; i++) begin : g_cand
    assign cand_qos[i] = req_write[i] ? wr_qos[i] : rd_qos[i];
  end

  assign any_req = |req;

  always_comb begin
    logic [KEY_W-1:0] best;
    logic             found;
    best    = '0;
    found   = 1'b0;
    win_idx = '0;
    for (int i = 0; i < N_MST; i++) begin
      if (req[i] && (!found || sort_key(cand_qos[i], rank[i]) > best)) begin
        found   = 1'b1;
        best    = sort_key(cand_qos[i], rank[i]);
        win_idx = IDX_W'(i);
      end
    end
    win_qos = cand_qos[win_idx];
  end
endmodule

// File: rtl/qos_lrg_arbiter.sv
`timescale 1ns/1ps
module qos_lrg_arbiter #(
  parameter int N_MST = 4,
  parameter int QOS_W = 4,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_MST-1:0] req,
  input  logic [N_MST-1:0] req_write,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_master,
  input  logic [1:0]       cfg_sel,
  input  logic [QOS_W-1:0] cfg_data,
  output logic [N_MST-1:0] grant,
  output logic             grant_valid,
  output logic             config_error
);
  localparam logic [IDX_W-1:0] NEWEST = IDX_W'(N_MST - 1);

  logic [N_MST-1:0][QOS_W-1:0] rd_qos, wr_qos, cand_qos;
  logic [N_MST-1:0][1:0]       grp;
  logic [N_MST-1:0][IDX_W-1:0] rank;
  logic                        any_req;
  logic [IDX_W-1:0]            win_idx;
  logic [QOS_W-1:0]            win_qos;

  qarb_cfg_regs #(.N_MST(N_MST), .QOS_W(QOS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_master(cfg_master),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .rd_qos(rd_qos), .wr_qos(wr_qos), .grp(grp)
  );

  qarb_band_check #(.N_MST(N_MST), .QOS_W(QOS_W)) u_band (
    .rd_qos(rd_qos), .wr_qos(wr_qos), .grp(grp), .cfg_err(config_error)
  );

  qarb_select #(.N_MST(N_MST), .QOS_W(QOS_W)) u_sel (
    .req(req), .req_write(req_write), .rd_qos(rd_qos), .wr_qos(wr_qos),
    .rank(rank), .cand_qos(cand_qos), .any_req(any_req),
    .win_idx(win_idx), .win_qos(win_qos)
  );

  qarb_age_rank #(.N_MST(N_MST)) u_age (
    .clk(clk), .rst_n(rst_n), .upd(any_req), .win_idx(win_idx), .rank(rank)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant       <= '0;
      grant_valid <= 1'b0;
    end else begin
      grant_valid <= any_req;
      grant       <= any_req ? (N_MST'(1) << win_idx) : '0;
    end
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> $onehot(grant));

  // R2
  grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~$past(req)) == '0);

  // R6
  idle_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_req |=> ($stable(rank) && !grant_valid));

  for (genvar i = 0; i < N_MST; i++) begin : g_chk
    // R5
    newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] |-> (rank[i] == NEWEST));

    // R3
    qos_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && $past(req[i])) |-> ($past(cand_qos[i]) <= $past(win_qos)));
  end
endmodule

// File: tb/qos_lrg_arbiter_test.sv
`timescale 1ns/1ps
module qos_lrg_arbiter_test;
  localparam int N  = 4;
  localparam int QW = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0, req_write = '0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_master = '0;
  logic [1:0]    cfg_sel = '0;
  logic [QW-1:0] cfg_data = '0;
  logic [N-1:0]  grant;
  logic          grant_valid, config_error;

  qos_lrg_arbiter #(.N_MST(N), .QOS_W(QW)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
    .cfg_we(cfg_we), .cfg_master(cfg_master), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .grant(grant), .grant_valid(grant_valid),
    .config_error(config_error)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc++;

  typedef struct { int due; logic [N-1:0] g; logic v; string tag; } item_t;
  item_t sb[$];

  // bench model: levels, groups (0 high,1 mid,2 low), order list oldest first
  int m_rd[N], m_wr[N], m_grp[N];
  int lru[$];

  task automatic step(input logic [N-1:0] r, input logic [N-1:0] w,
                      input bit we, input int m, input int sel, input int d,
                      input string tag);
    item_t it;
    int win, best, pos;
    @(posedge clk); #2;
    req = r; req_write = w; cfg_we = we;
    cfg_master = m[IW-1:0]; cfg_sel = sel[1:0]; cfg_data = d[QW-1:0];
    win = -1; best = -1; pos = -1;
    foreach (lru[k]) begin
      int idx, q;
      idx = lru[k];
      if (r[idx]) begin
        q = w[idx] ? m_wr[idx] : m_rd[idx];
        if (q > best) begin best = q; win = idx; pos = k; end
      end
    end
    if (win >= 0) begin lru.delete(pos); lru.push_back(win); end
    it.due = cyc + 1;
    it.g   = (win >= 0) ? (N'(1) << win) : '0;
    it.v   = (win >= 0);
    it.tag = tag;
    sb.push_back(it);
    if (we) begin
      if (sel == 0) m_rd[m] = d;
      else if (sel == 1) m_wr[m] = d;
      else if (sel == 2) m_grp[m] = ((d & 3) == 3) ? 2 : (d & 3);
    end
  endtask

  task automatic arb(input logic [N-1:0] r, input logic [N-1:0] w, input string tag);
    step(r, w, 0, 0, 0, 0, tag);
  endtask

  task automatic cfg(input int m, input int sel, input int d);
    step('0, '0, 1, m, sel, d, "R7");
  endtask

  function automatic bit model_err();
    for (int lo = 1; lo <= 2; lo++)
      for (int hi = 0; hi < lo; hi++)
        for (int a = 0; a < N; a++)
          for (int b = 0; b < N; b++)
            if (m_grp[a] == lo && m_grp[b] == hi) begin
              int amax, bmin;
              amax = (m_rd[a] > m_wr[a]) ? m_rd[a] : m_wr[a];
              bmin = (m_rd[b] < m_wr[b]) ? m_rd[b] : m_wr[b];
              if (amax >= bmin) return 1;
            end
    return 0;
  endfunction

  task automatic check_err(input string tag);
    bit exp;
    arb('0, '0, "R6");
    @(negedge clk);
    exp = model_err();
    checks++;
    if (config_error !== exp) begin
      errors++;
      $display("FAIL %s config_error=%b expected=%b", tag, config_error, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (grant !== it.g || grant_valid !== it.v) begin
        errors++;
        $display("FAIL %s grant=%b valid=%b expected grant=%b valid=%b",
                 it.tag, grant, grant_valid, it.g, it.v);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_rd[i] = 0; m_wr[i] = 0; m_grp[i] = 0; lru.push_back(i); end

    // R1 reset state
    repeat (3) @(negedge clk);
    checks++;
    if (grant !== '0 || grant_valid !== 1'b0 || config_error !== 1'b0) begin
      errors++;
      $display("FAIL R1 grant=%b valid=%b err=%b expected 0000 0 0", grant, grant_valid, config_error);
    end
    @(posedge clk); #2; rst_n = 1'b1;

    // R5 equal levels rotate from master 0
    for (int k = 0; k < 4; k++) arb(4'b1111, 4'b0000, "R5");
    // R6 idle keeps ranking; R5 tie resolved by age after idle
    arb(4'b0110, 4'b0000, "R5");
    arb('0, '0, "R6");
    arb('0, '0, "R6");
    arb(4'b0110, 4'b0000, "R6");
    // R2 single requesters
    for (int k = 0; k < N; k++) arb(N'(1) << k, '0, "R2");

    // R7 write takes effect at the next arbitration; R3 highest level wins
    cfg(2, 0, 5);
    arb(4'b1111, 4'b0000, "R3");
    arb(4'b1111, 4'b0000, "R3");
    // R4 read/write level selection
    cfg(3, 1, 9);
    arb(4'b1100, 4'b0000, "R4");
    arb(4'b1100, 4'b1000, "R4");
    arb(4'b1100, 4'b0100, "R4");
    // R7 same-cycle write and request uses the old value
    step(4'b0011, 4'b0000, 1, 0, 0, 3, "R7");
    arb(4'b0011, 4'b0000, "R7");

    // R8 band ordering
    cfg(0, 0, 0);
    cfg(0, 2, 2);
    cfg(1, 2, 1);
    check_err("R8");
    cfg(1, 0, 1);
    cfg(1, 1, 1);
    check_err("R8");
    cfg(2, 1, 6);
    cfg(3, 0, 7);
    check_err("R8");
    cfg(2, 2, 3);
    check_err("R8");
    // R9 arbitration on raw levels while error is high
    arb(4'b0101, 4'b0000, "R9");
    arb(4'b0011, 4'b0000, "R9");
    arb(4'b0111, 4'b0100, "R9");
    // R8 empty middle group
    cfg(1, 2, 0);
    check_err("R8");
    cfg(2, 2, 0);
    check_err("R8");

    // random phase
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(0, 5) == 0)
        cfg($urandom_range(0, N-1), $urandom_range(0, 1), $urandom_range(0, 15));
      else
        arb(N'($urandom_range(0, 15)), N'($urandom_range(0, 15)), "R5");
      if (k % 50 == 49) check_err("R8");
    end

    arb('0, '0, "R6");
    repeat (4) @(posedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule